// File: doc/BRIEF.md
# Per-CPU Hotplug Register Window

This block gives firmware a small register window onto the hotplug state of a set of processors, one processor at a time. A selector register picks the processor. Once it is picked, firmware can read its enabled flag and its pending insert and remove events, acknowledge those events, start an eject or hand the eject over to firmware, and read a 64-bit architecture identifier. A command byte chooses what the two dword data registers return or accept. One command scans for the lowest-numbered processor with a pending event and moves the selector to it, so a single read then tells firmware which processor needs attention.

The platform side raises insert and remove requests through one request line per processor. The block reports two things outward: an eject pulse that carries the processor index, and a status-report pulse that carries the last written report event and report status words. The bus is a simple I/O bus. Each cycle carries at most one access, either a byte or a dword. Read data is combinational and valid in the same cycle as the read strobe.

Top module: `cpu_hp_regwin`

## Requirements
- R1: A dword write at offset 0x0 loads the 32-bit selector. Only values 0 to MAX_CPUS-1 are valid. The selector powers up as 0, and reset leaves its value unchanged.
- R2: While the selector holds a value of MAX_CPUS or above, every read returns 0 and every write other than the selector write is dropped.
- R3: A byte read at offset 0x4 returns the status of the selected processor. Bit 0 is the enabled flag, bit 1 the pending insert event, bit 2 the pending remove event and bit 4 the firmware eject handover flag. Bits 3, 5, 6 and 7 read 0. Byte data travels on bits 7:0.
- R4: A byte write at offset 0x4 with bit 1 set clears the selected processor's insert event. With bit 2 set it clears the remove event.
- R5: A byte write at offset 0x4 with bit 4 set raises the selected processor's handover flag, unless the same write also starts an eject.
- R6: A byte write at offset 0x4 with bit 3 set ejects the selected processor. It clears the enabled and handover flags. In the next cycle `eject_pulse` is high for one cycle and `eject_cpu` holds the processor index.
- R7: A high `ins_req[i]` for one cycle sets the enabled flag and the insert event of processor i. A high `rem_req[i]` sets its remove event. A request wins over a clear written in the same cycle.
- R8: A byte write of command value 0 at offset 0x5 moves the selector to the lowest-numbered processor that has an insert or a remove event pending. If no processor has one, the selector and all flags stay unchanged.
- R9: With command 0 stored, a dword read at offset 0x8 returns the selector and a dword read at offset 0x0 returns 0.
- R10: With command 3 stored, a dword read at offset 0x8 returns ID_BASE + index*ID_STEP. A dword read at offset 0x0 returns {ID_TAG, index[15:0]}.
- R11: With command 1 stored, a dword write at offset 0x8 loads the report event word. With command 2 stored, the same write loads the report status word and raises `ost_pulse` for one cycle, with both words on `ost_event` and `ost_status`.
- R12: Reserved offsets, reserved access sizes and reserved command values read 0 and ignore writes. Dword data is little-endian: bits 7:0 hold the lowest offset.
- R13: After reset, all events and handover flags are clear, only processor 0 is enabled, the command is 0, and both report words and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (does not touch the selector) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_dw | input | 1 | Access size: 1 = dword, 0 = byte |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data; a byte uses bits 7:0 |
| bus_rdata | output | 32 | Read data, same cycle as bus_rd; 0 when idle |
| ins_req | input | MAX_CPUS | Per-processor insert request |
| rem_req | input | MAX_CPUS | Per-processor remove request |
| eject_pulse | output | 1 | One-cycle eject notification |
| eject_cpu | output | IDX_W | Index of the ejected processor |
| ost_pulse | output | 1 | One-cycle status-report notification |
| ost_event | output | 32 | Last written report event word |
| ost_status | output | 32 | Last written report status word |

## Verification
The assertions assume that each cycle carries at most one bus access and never a read and a write together. They also assume that a write whose outcome is being checked has no request pulse beside it, except in the case where request-over-clear priority is the thing under test. The stimulus keeps to these limits. Every access is issued from a task that drives exactly one strobe for one cycle. Insert and remove requests are pulsed in cycles of their own, apart from a single directed case that lines a request up with a clear. Selector values are drawn partly beyond MAX_CPUS, so the blocked paths get regular use.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

  // window offsets (the decoder depends on these)
  localparam logic [3:0] OFS_SEL   = 4'h0;
  localparam logic [3:0] OFS_FLAGS = 4'h4;
  localparam logic [3:0] OFS_CMD   = 4'h5;
  localparam logic [3:0] OFS_DATA  = 4'h8;

  // command codes
  localparam logic [7:0] CMD_SCAN    = 8'd0;
  localparam logic [7:0] CMD_OST_EV  = 8'd1;
  localparam logic [7:0] CMD_OST_ST  = 8'd2;
  localparam logic [7:0] CMD_ARCH_ID = 8'd3;

  // control byte bit positions
  localparam int CTL_CLR_INS = 1;
  localparam int CTL_CLR_REM = 2;
  localparam int CTL_EJECT   = 3;
  localparam int CTL_HANDOFF = 4;

  typedef struct packed {
    logic handoff;
    logic rem;
    logic ins;
    logic en;
  } hpw_flags_t;

  function automatic logic [7:0] pack_status(input hpw_flags_t f);
    return {3'b000, f.handoff, 1'b0, f.rem, f.ins, f.en};
  endfunction

  function automatic logic [63:0] arch_id(input logic [31:0] idx,
                                          input logic [31:0] base,
                                          input logic [31:0] step,
                                          input logic [15:0] tag);
    logic [31:0] lo;
    lo = base + idx * step;
    return {tag, idx[15:0], lo};
  endfunction

endpackage

// File: rtl/hpw_cpu_slot.sv
module hpw_cpu_slot
  import hpw_pkg::*;
#(
  parameter bit EN_AT_RESET = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ins_req_i,
  input  logic       rem_req_i,
  input  logic       clr_ins_i,
  input  logic       clr_rem_i,
  input  logic       handoff_i,
  input  logic       eject_i,
  output hpw_flags_t flags_o
);

  logic en_q, ins_q, rem_q, fw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= EN_AT_RESET;
      ins_q <= 1'b0;
      rem_q <= 1'b0;
      fw_q  <= 1'b0;
    end else begin
      if (eject_i)        en_q <= 1'b0;
      else if (ins_req_i) en_q <= 1'b1;

      if (ins_req_i)      ins_q <= 1'b1;
      else if (clr_ins_i) ins_q <= 1'b0;

      if (rem_req_i)      rem_q <= 1'b1;
      else if (clr_rem_i) rem_q <= 1'b0;

      if (eject_i)        fw_q <= 1'b0;
      else if (handoff_i) fw_q <= 1'b1;
    end
  end

  assign flags_o = '{handoff: fw_q, rem: rem_q, ins: ins_q, en: en_q};

  p_eject_drops_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eject_i |=> (!en_q && !fw_q));

  p_request_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req_i |=> (ins_q && en_q));

  p_clear_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ins_i && !ins_req_i) |=> !ins_q);

  p_handoff_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff_i && !eject_i) |=> fw_q);

endmodule

// File: rtl/hpw_pend_search.sv
module hpw_pend_search #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  pend_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);

  // walk downward so the lowest set index is the one left standing
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

endmodule

// File: rtl/hpw_access_dec.sv
module hpw_access_dec
  import hpw_pkg::*;
(
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       dw_i,
  input  logic [3:0] addr_i,
  input  logic       sel_ok_i,
  output logic       we_sel_o,
  output logic       we_ctl_o,
  output logic       we_cmd_o,
  output logic       we_data_o,
  output logic       re_hi_o,
  output logic       re_flags_o,
  output logic       re_data_o
);

  logic dw_at_sel, byte_at_flags, byte_at_cmd, dw_at_data;

  assign dw_at_sel     = dw_i && (addr_i == OFS_SEL);
  assign byte_at_flags = !dw_i && (addr_i == OFS_FLAGS);
  assign byte_at_cmd   = !dw_i && (addr_i == OFS_CMD);
  assign dw_at_data    = dw_i && (addr_i == OFS_DATA);

  // the selector write is the only one that passes an out-of-range selector
  assign we_sel_o   = wr_i && dw_at_sel;
  assign we_ctl_o   = wr_i && sel_ok_i && byte_at_flags;
  assign we_cmd_o   = wr_i && sel_ok_i && byte_at_cmd;
  assign we_data_o  = wr_i && sel_ok_i && dw_at_data;

  assign re_hi_o    = rd_i && sel_ok_i && dw_at_sel;
  assign re_flags_o = rd_i && sel_ok_i && byte_at_flags;
  assign re_data_o  = rd_i && sel_ok_i && dw_at_data;

endmodule

// File: rtl/cpu_hp_regwin.sv
module cpu_hp_regwin
  import hpw_pkg::*;
#(
  parameter int          MAX_CPUS = 8,
  parameter logic [31:0] ID_BASE  = 32'h0000_0020,
  parameter logic [31:0] ID_STEP  = 32'h0000_0002,
  parameter logic [15:0] ID_TAG   = 16'hA5C3,
  localparam int         IDX_W    = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_dw,
  input  logic [3:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [MAX_CPUS-1:0] ins_req,
  input  logic [MAX_CPUS-1:0] rem_req,
  output logic                eject_pulse,
  output logic [IDX_W-1:0]    eject_cpu,
  output logic                ost_pulse,
  output logic [31:0]         ost_event,
  output logic [31:0]         ost_status
);

  // ---------------- selector ----------------
  logic [31:0]      sel_q = '0;   // power-up value; reset does not touch it
  logic             sel_ok;
  logic [IDX_W-1:0] sel_idx;

  assign sel_ok  = (sel_q < 32'(MAX_CPUS));
  assign sel_idx = sel_q[IDX_W-1:0];

  // ---------------- decode ----------------
  logic we_sel, we_ctl, we_cmd, we_data, re_hi, re_flags, re_data;

  hpw_access_dec u_dec (
    .wr_i       (bus_wr),
    .rd_i       (bus_rd),
    .dw_i       (bus_dw),
    .addr_i     (bus_addr),
    .sel_ok_i   (sel_ok),
    .we_sel_o   (we_sel),
    .we_ctl_o   (we_ctl),
    .we_cmd_o   (we_cmd),
    .we_data_o  (we_data),
    .re_hi_o    (re_hi),
    .re_flags_o (re_flags),
    .re_data_o  (re_data)
  );

  // ---------------- command ----------------
  logic [7:0] cmd_q;
  logic       scan_fire;

  assign scan_fire = we_cmd && (bus_wdata[7:0] == CMD_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= CMD_SCAN;
    else if (we_cmd) cmd_q <= bus_wdata[7:0];
  end

  // ---------------- per-processor state ----------------
  hpw_flags_t            flags_a [MAX_CPUS];
  logic [MAX_CPUS-1:0]   pend;
  logic                  ctl_eject;

  assign ctl_eject = we_ctl && bus_wdata[CTL_EJECT];

  for (genvar g = 0; g < MAX_CPUS; g++) begin : g_slot
    logic picked;
    assign picked = (sel_idx == IDX_W'(g));

    hpw_cpu_slot #(.EN_AT_RESET(g == 0)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_req_i (ins_req[g]),
      .rem_req_i (rem_req[g]),
      .clr_ins_i (we_ctl && picked && bus_wdata[CTL_CLR_INS]),
      .clr_rem_i (we_ctl && picked && bus_wdata[CTL_CLR_REM]),
      .handoff_i (we_ctl && picked && bus_wdata[CTL_HANDOFF]),
      .eject_i   (ctl_eject && picked),
      .flags_o   (flags_a[g])
    );

    assign pend[g] = flags_a[g].ins | flags_a[g].rem;
  end

  // ---------------- pending-event scan ----------------
  logic             scan_hit;
  logic [IDX_W-1:0] scan_idx;

  hpw_pend_search #(.N(MAX_CPUS), .IW(IDX_W)) u_scan (
    .pend_i (pend),
    .hit_o  (scan_hit),
    .idx_o  (scan_idx)
  );

  always_ff @(posedge clk) begin
    if (we_sel)                     sel_q <= bus_wdata;
    else if (scan_fire && scan_hit) sel_q <= 32'(scan_idx);
  end

  // ---------------- eject notification ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eject_pulse <= 1'b0;
      eject_cpu   <= '0;
    end else begin
      eject_pulse <= ctl_eject;
      if (ctl_eject) eject_cpu <= sel_idx;
    end
  end

  // ---------------- status report words ----------------
  logic ost_ev_we, ost_st_we;

  assign ost_ev_we = we_data && (cmd_q == CMD_OST_EV);
  assign ost_st_we = we_data && (cmd_q == CMD_OST_ST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ost_event  <= '0;
      ost_status <= '0;
      ost_pulse  <= 1'b0;
    end else begin
      ost_pulse <= ost_st_we;
      if (ost_ev_we) ost_event  <= bus_wdata;
      if (ost_st_we) ost_status <= bus_wdata;
    end
  end

  // ---------------- read path ----------------
  hpw_flags_t  sel_flags;
  logic [63:0] sel_id;

  assign sel_flags = sel_ok ? flags_a[sel_idx] : '0;
  assign sel_id    = arch_id(32'(sel_idx), ID_BASE, ID_STEP, ID_TAG);

  always_comb begin
    bus_rdata = '0;
    if (re_hi) begin
      if (cmd_q == CMD_ARCH_ID) bus_rdata = sel_id[63:32];
    end else if (re_flags) begin
      bus_rdata = {24'b0, pack_status(sel_flags)};
    end else if (re_data) begin
      if (cmd_q == CMD_SCAN)         bus_rdata = sel_q;
      else if (cmd_q == CMD_ARCH_ID) bus_rdata = sel_id[31:0];
    end
  end

  // ---------------- assertions ----------------
  p_blocked_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !sel_ok) |-> (bus_rdata == 32'd0));

  p_blocked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !sel_ok) |=> ($stable(cmd_q) && !eject_pulse && !ost_pulse));

  p_scan_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_fire && scan_hit) |=> (sel_q == 32'($past(scan_idx))));

  p_scan_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_fire && !scan_hit) |=> $stable(sel_q));

  p_eject_carries_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_eject |=> (eject_pulse && eject_cpu == $past(sel_idx)));

  p_ost_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ost_st_we |=> (ost_pulse && ost_status == $past(bus_wdata)));

  p_sel_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we_sel |=> (sel_q == $past(bus_wdata)));

endmodule

// File: tb/cpu_hp_regwin_tb.sv
module cpu_hp_regwin_tb;

  localparam int          CLK_PERIOD = 10;
  localparam int          MAX        = 6;
  localparam int          IW         = 3;
  localparam logic [31:0] BASE       = 32'h0000_0100;
  localparam logic [31:0] STEP       = 32'h0000_0004;
  localparam logic [15:0] TAG        = 16'h3C5A;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0, bus_dw = 1'b0;
  logic [3:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [MAX-1:0]  ins_req = '0, rem_req = '0;
  logic            eject_pulse, ost_pulse;
  logic [IW-1:0]   eject_cpu;
  logic [31:0]     ost_event, ost_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_hp_regwin #(.MAX_CPUS(MAX), .ID_BASE(BASE), .ID_STEP(STEP), .ID_TAG(TAG)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_dw(bus_dw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ins_req(ins_req), .rem_req(rem_req), .eject_pulse(eject_pulse),
    .eject_cpu(eject_cpu), .ost_pulse(ost_pulse), .ost_event(ost_event),
    .ost_status(ost_status)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // reference model
  bit          m_en [MAX], m_ins [MAX], m_rem [MAX], m_fw [MAX];
  logic [31:0] m_sel;
  logic [7:0]  m_cmd;
  logic [31:0] m_ev, m_st;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] id_lo(input logic [31:0] i);
    return BASE + (i << 2) * (STEP >> 2);
  endfunction

  function automatic logic [31:0] id_hi(input logic [31:0] i);
    return (32'(TAG) << 16) | (i & 32'h0000_FFFF);
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a, input bit dw);
    int s;
    if (m_sel >= MAX) return 0;
    s = int'(m_sel);
    if (dw && a == 4'h0) return (m_cmd == 8'd3) ? id_hi(m_sel) : 0;
    if (!dw && a == 4'h4)
      return 32'(m_en[s]) | (32'(m_ins[s]) << 1) | (32'(m_rem[s]) << 2) | (32'(m_fw[s]) << 4);
    if (dw && a == 4'h8) begin
      if (m_cmd == 8'd0) return m_sel;
      if (m_cmd == 8'd3) return id_lo(m_sel);
    end
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < MAX; i++) begin
      m_en[i] = (i == 0); m_ins[i] = 0; m_rem[i] = 0; m_fw[i] = 0;
    end
    m_cmd = 0; m_ev = 0; m_st = 0;
  endtask

  task automatic do_write(input string req, input logic [3:0] a, input bit dw, input logic [31:0] d);
    bit exp_ej, exp_ost;
    int s;
    exp_ej = 0; exp_ost = 0;
    @(negedge clk);
    bus_wr = 1; bus_dw = dw; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (dw && a == 4'h0) m_sel = d;
    else if (m_sel < MAX) begin
      s = int'(m_sel);
      if (!dw && a == 4'h4) begin
        if (d[1]) m_ins[s] = 0;
        if (d[2]) m_rem[s] = 0;
        if (d[4]) m_fw[s] = 1;
        if (d[3]) begin m_en[s] = 0; m_fw[s] = 0; exp_ej = 1; end
      end else if (!dw && a == 4'h5) begin
        m_cmd = d[7:0];
        if (m_cmd == 0) begin
          for (int i = MAX - 1; i >= 0; i--) if (m_ins[i] || m_rem[i]) m_sel = 32'(i);
        end
      end else if (dw && a == 4'h8) begin
        if (m_cmd == 8'd1) m_ev = d;
        if (m_cmd == 8'd2) begin m_st = d; exp_ost = 1; end
      end
    end
    check({req, " eject pulse"}, 32'(eject_pulse), 32'(exp_ej));
    if (exp_ej) check({req, " eject index R6"}, 32'(eject_cpu), m_sel);
    check({req, " report pulse"}, 32'(ost_pulse), 32'(exp_ost));
    if (exp_ost) begin
      check({req, " report event R11"}, ost_event, m_ev);
      check({req, " report status R11"}, ost_status, m_st);
    end
  endtask

  task automatic do_read(input string req, input logic [3:0] a, input bit dw);
    logic [31:0] v;
    @(negedge clk);
    bus_rd = 1; bus_dw = dw; bus_addr = a;
    #1 v = bus_rdata;
    bus_rd = 0;
    check(req, v, exp_read(a, dw));
  endtask

  task automatic pulse_req(input bit rem, input int i);
    @(negedge clk);
    if (rem) rem_req[i] = 1; else ins_req[i] = 1;
    @(negedge clk);
    ins_req = '0; rem_req = '0;
    if (rem) m_rem[i] = 1; else begin m_ins[i] = 1; m_en[i] = 1; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_sel = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R13 / R9 / R3: state after reset
    do_read("R13 R9 selector after reset", 4'h8, 1);
    do_read("R13 R3 status cpu0 after reset", 4'h4, 0);
    do_read("R9 data2 reads 0 on command 0", 4'h0, 1);
    check("R13 report words reset", ost_event | ost_status, 0);

    // R7 / R8: insert on cpu 4, scan finds it
    pulse_req(0, 4);
    do_write("R8 scan", 4'h5, 0, 32'h0);
    do_read("R8 scan moved selector", 4'h8, 1);
    do_read("R7 R3 insert status", 4'h4, 0);

    // R10: architecture id
    do_write("R10 cmd3", 4'h5, 0, 32'h3);
    do_read("R10 id low", 4'h8, 1);
    do_read("R10 id high", 4'h0, 1);

    // R2: out-of-range selector
    do_write("R1 sel 6", 4'h0, 1, 32'd6);
    do_read("R2 blocked status", 4'h4, 0);
    do_read("R2 blocked data", 4'h8, 1);
    do_write("R2 blocked cmd", 4'h5, 0, 32'h0);
    do_write("R2 blocked ctl", 4'h4, 0, 32'h08);
    do_write("R1 sel 4", 4'h0, 1, 32'd4);
    do_read("R2 command kept at 3", 4'h8, 1);
    do_read("R2 flags untouched", 4'h4, 0);

    // R4 clear insert, R8 miss
    do_write("R4 clear insert", 4'h4, 0, 32'h02);
    do_read("R4 insert cleared", 4'h4, 0);
    do_write("R1 sel 2", 4'h0, 1, 32'd2);
    do_write("R8 scan miss", 4'h5, 0, 32'h0);
    do_read("R8 selector unchanged on miss", 4'h8, 1);

    // R7 request wins over a clear in the same cycle
    pulse_req(1, 2);
    @(negedge clk);
    bus_wr = 1; bus_dw = 0; bus_addr = 4'h4; bus_wdata = 32'h04; rem_req[2] = 1;
    @(negedge clk);
    bus_wr = 0; rem_req = '0;
    do_read("R7 remove survives clear", 4'h4, 0);
    do_write("R4 clear remove", 4'h4, 0, 32'h04);
    do_read("R4 remove cleared", 4'h4, 0);

    // R5 / R6
    pulse_req(0, 2);
    do_write("R5 handoff", 4'h4, 0, 32'h10);
    do_read("R5 handoff visible", 4'h4, 0);
    do_write("R6 eject", 4'h4, 0, 32'h08);
    do_read("R6 enabled and handoff cleared", 4'h4, 0);
    do_write("R5 R6 handoff with eject", 4'h4, 0, 32'h18);
    do_read("R5 eject beats handoff", 4'h4, 0);

    // R11 report words
    do_write("R11 cmd1", 4'h5, 0, 32'h1);
    do_write("R11 event", 4'h8, 1, 32'hDEAD_BEEF);
    do_write("R11 cmd2", 4'h5, 0, 32'h2);
    do_write("R11 status", 4'h8, 1, 32'h0000_1234);

    // R12 reserved
    do_write("R12 cmd 7", 4'h5, 0, 32'h7);
    do_read("R12 reserved command data", 4'h8, 1);
    do_read("R12 byte read at 0", 4'h0, 0);
    do_read("R12 dword read at 4", 4'h4, 1);
    do_write("R12 dword write at 4", 4'h4, 1, 32'hFFFF_FFFF);
    do_read("R12 status unchanged", 4'h4, 0);
    do_write("R12 byte write at 0", 4'h0, 0, 32'h5);
    do_write("R12 back to cmd0", 4'h5, 0, 32'h0);
    do_read("R12 selector not moved by byte write", 4'h8, 1);

    // R1: reset keeps selector
    do_write("R1 sel 3", 4'h0, 1, 32'd3);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    model_reset();
    do_read("R1 selector kept across reset", 4'h8, 1);
    do_read("R13 flags cleared by reset", 4'h4, 0);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom % 9);
      case (op)
        0: begin
          v = ($urandom % 8 == 0) ? 32'hFFFF_FFF0 : 32'($urandom % (MAX + 3));
          do_write("R1 random selector", 4'h0, 1, v);
        end
        1: begin
          v = 32'($urandom % 256);
          if ($urandom % 4 != 0) v[3] = 1'b0;
          do_write("R4 R5 R6 random control", 4'h4, 0, v);
        end
        2: do_write("R8 random command", 4'h5, 0, 32'($urandom % 5));
        3: do_write("R11 random data", 4'h8, 1, $urandom);
        4: pulse_req(0, int'($urandom % MAX));
        5: pulse_req(1, int'($urandom % MAX));
        6: do_read("R3 random status", 4'h4, 0);
        7: do_read("R9 R10 random data", 4'h8, 1);
        default: do_read("R10 R12 random data2", 4'h0, 1);
      endcase
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule